// File: doc/BRIEF.md
# Dual-Channel Bus Breakpoint Comparator

This block sits beside a processor bus and flags bus cycles that meet conditions programmed into a small bank of byte-wide configuration registers. Each bus cycle presents a 16-bit address, a 16-bit data word, a read/write strobe and a cycle-valid qualifier. The block compares these against the programmed values and raises per-channel match flags in the same cycle. One clock later it raises a registered breakpoint request, which is the OR of the two flags.

The block has two modes. In full mode only channel 0 is active: it needs the address to equal compare set 0 and the data bus to equal compare set 1. In dual mode both channels are active and compare addresses only: channel 0 against set 0 and channel 1 against set 1. Each channel can also be limited to read cycles or to write cycles. A channel marked as a program (fetch) breakpoint ignores its direction settings.

Configuration is written through a synchronous strobe interface. Register select 0 is the control byte. Selects 1 and 2 hold the high and low bytes of compare set 0. Selects 3 and 4 hold the high and low bytes of compare set 1. Selects 5 to 7 are not used.

Top module: `bkpt_top`

## Requirements
- R1: While reset is high and in the cycle after it, every configuration register is 0, both match flags are 0 and brk_req is 0.
- R2: Control bit 0 is the global enable. While it is 0, both match flags are 0 whatever the bus does.
- R3: While bus_valid is 0, both match flags are 0.
- R4: An address match needs equality on all 16 bits. Select 1 supplies bits 15:8 and select 2 supplies bits 7:0 of compare set 0. Selects 3 and 4 do the same for compare set 1.
- R5: With control bit 1 at 0 (full mode), match[0] also needs bus_data to equal compare set 1, and match[1] stays 0.
- R6: With control bit 1 at 1 (dual mode), match[0] compares bus_addr with set 0 and match[1] compares bus_addr with set 1. Neither channel looks at the data bus.
- R7: When a channel's direction enable is 0, its match does not depend on bus_rw. Channel 0's direction enable is control bit 2 and channel 1's is control bit 4.
- R8: When a channel's direction enable is 1, its direction value selects the cycle type: value 0 matches only writes (bus_rw=0) and value 1 matches only reads (bus_rw=1). Channel 0's value is control bit 3 and channel 1's is control bit 5.
- R9: In full mode, channel 1's direction bits (control bits 4 and 5) have no effect on any output.
- R10: When a channel's program bit is 1, its direction bits have no effect on its match. Channel 0's program bit is control bit 6 and channel 1's is control bit 7.
- R11: brk_req equals the OR of the match flags of the previous clock cycle.
- R12: A configuration write takes effect from the cycle after the strobe. The compare in the same cycle uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write byte |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 16 | Bus data |
| bus_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_valid | input | 1 | Bus cycle qualifier |
| match | output | 2 | Per-channel match flags (combinational) |
| brk_req | output | 1 | Registered combined breakpoint request |

## Verification
The directed cases target the places where a comparator is most often wrong:
- A miss on only the high byte or only the low byte of the address catches a design that compares just part of the address.
- A data mismatch in full mode catches a design that drops the data qualifier.
- Channel 1's direction bits set while in full mode catch a design that lets them gate channel 0.
- A write cycle against a read-only program breakpoint catches a design that applies direction bits to fetch matches.
- A control write in the same cycle as a hitting bus cycle catches a compare path that bypasses the register.

Constrained-random cycles, biased toward the programmed addresses, then check both flags and the one-cycle-late request against a reference model.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int BUS_W  = 16;
    localparam int BYTE_W = 8;
    localparam int NBYTES = BUS_W / BYTE_W;
    localparam int NREGS  = 1 + 2 * NBYTES;
    localparam int SEL_W  = $clog2(NREGS);
    localparam int NCHAN  = 2;

    // Control byte layout, bit 7 down to bit 0
    typedef struct packed {
        logic prog1;
        logic prog0;
        logic d1val;
        logic d1en;
        logic d0val;
        logic d0en;
        logic dual;
        logic en;
    } ctl_t;

    // Per-channel qualification settings
    typedef struct packed {
        logic prog;
        logic den;
        logic dval;
        logic on;
        logic use_data;
    } chan_cfg_t;

    // Direction filter: program matches and disabled filters pass every cycle
    function automatic logic dir_pass(input logic prog, input logic den,
                                      input logic dval, input logic rw);
        return prog || !den || (rw == dval);
    endfunction

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [7:0]       wdata,
    output ctl_t             ctl,
    output logic [W-1:0]     set0,
    output logic [W-1:0]     set1
);
    localparam int NB = W / BYTE_W;

    always_ff @(posedge clk) begin
        if (rst)
            ctl <= '0;
        else if (we && sel == '0)
            ctl <= ctl_t'(wdata);
    end

    // Lower select numbers hold the more significant bytes
    for (genvar b = 0; b < NB; b++) begin : g_byte
        localparam int SEL0 = 1 + (NB - 1 - b);
        localparam int SEL1 = 1 + NB + (NB - 1 - b);
        always_ff @(posedge clk) begin
            if (rst) begin
                set0[b*BYTE_W +: BYTE_W] <= '0;
                set1[b*BYTE_W +: BYTE_W] <= '0;
            end else if (we) begin
                if (sel == SEL_W'(SEL0))
                    set0[b*BYTE_W +: BYTE_W] <= wdata;
                if (sel == SEL_W'(SEL1))
                    set1[b*BYTE_W +: BYTE_W] <= wdata;
            end
        end
    end

endmodule

// File: rtl/bkpt_chan.sv
module bkpt_chan
    import bkpt_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic         active,
    input  chan_cfg_t    cfg,
    input  logic [W-1:0] cmp_addr,
    input  logic [W-1:0] cmp_data,
    input  logic [W-1:0] addr,
    input  logic [W-1:0] data,
    input  logic         rw,
    output logic         hit
);
    logic addr_eq, data_ok, dir_ok;

    always_comb begin
        addr_eq = (addr == cmp_addr);
        data_ok = !cfg.use_data || (data == cmp_data);
        dir_ok  = dir_pass(cfg.prog, cfg.den, cfg.dval, rw);
        hit     = active && cfg.on && addr_eq && data_ok && dir_ok;
    end

endmodule

// File: rtl/bkpt_top.sv
module bkpt_top
    import bkpt_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [7:0]         cfg_wdata,
    input  logic [W-1:0]       bus_addr,
    input  logic [W-1:0]       bus_data,
    input  logic               bus_rw,
    input  logic               bus_valid,
    output logic [NCHAN-1:0]   match,
    output logic               brk_req
);
    ctl_t         ctl_q;
    logic [W-1:0] set0, set1;
    logic         active;
    chan_cfg_t    ccfg [NCHAN];
    logic [W-1:0] caddr [NCHAN];

    bkpt_regs #(.W(W)) regs_i (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .ctl(ctl_q), .set0(set0), .set1(set1)
    );

    always_comb begin
        active = ctl_q.en && bus_valid;
        // Channel 0: always on, data-qualified in full mode
        ccfg[0] = '{prog: ctl_q.prog0, den: ctl_q.d0en, dval: ctl_q.d0val,
                    on: 1'b1, use_data: !ctl_q.dual};
        caddr[0] = set0;
        // Channel 1: second address compare, only in dual mode
        ccfg[1] = '{prog: ctl_q.prog1, den: ctl_q.d1en, dval: ctl_q.d1val,
                    on: ctl_q.dual, use_data: 1'b0};
        caddr[1] = set1;
    end

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        bkpt_chan #(.W(W)) chan_i (
            .active(active), .cfg(ccfg[c]), .cmp_addr(caddr[c]),
            .cmp_data(set1), .addr(bus_addr), .data(bus_data),
            .rw(bus_rw), .hit(match[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) brk_req <= 1'b0;
        else     brk_req <= |match;
    end

endmodule

// File: rtl/bkpt_chk.sv
module bkpt_chk
    import bkpt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_valid,
    input logic [NCHAN-1:0] match,
    input logic             brk_req,
    input logic             en,
    input logic             dual
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !brk_req);

    // R2
    gate_en_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> (match == '0));

    // R3
    gate_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> (match == '0));

    // R5
    full_ch1_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !dual |-> !match[1]);

    // R11
    req_follow_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (|match) |=> brk_req);

    // R11
    req_follow_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(|match) |=> !brk_req);

endmodule

bind bkpt_top bkpt_chk chk_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .match(match),
    .brk_req(brk_req), .en(ctl_q.en), .dual(ctl_q.dual)
);

// File: tb/bkpt_top_tb.sv
module bkpt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] bus_addr = '0, bus_data = '0;
    logic        bus_rw = 1'b0, bus_valid = 1'b0;
    logic [1:0]  match;
    logic        brk_req;

    int n_chk = 0, n_bad = 0;
    logic [7:0]  sh_ctl = '0;
    logic [15:0] sh_a0 = '0, sh_a1 = '0;

    always #10 clk = ~clk;

    bkpt_top dut_i (.*);

    function automatic logic [1:0] model(input logic [15:0] a, input logic [15:0] d,
                                         input logic rw, input logic v);
        logic d0, d1, m0, m1;
        if (!sh_ctl[0] || !v) return 2'b00;
        d0 = sh_ctl[6] || !sh_ctl[2] || (rw == sh_ctl[3]);
        d1 = sh_ctl[7] || !sh_ctl[4] || (rw == sh_ctl[5]);
        m0 = (a == sh_a0) && (sh_ctl[1] || d == sh_a1) && d0;
        m1 = sh_ctl[1] && (a == sh_a1) && d1;
        return {m1, m0};
    endfunction

    task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [2:0] sel, input logic [7:0] wd,
                       input logic [15:0] a, input logic [15:0] d, input logic rw,
                       input logic v, input string tag);
        logic [1:0] e;
        @(negedge clk);
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        bus_addr = a; bus_data = d; bus_rw = rw; bus_valid = v;
        #1;
        e = model(a, d, rw, v);
        check({tag, " match"}, match, e);
        @(posedge clk); #1;
        check({tag, " R11 brk_req"}, {1'b0, brk_req}, {1'b0, |e});
        if (we) begin
            case (sel)
                3'd0: sh_ctl = wd;
                3'd1: sh_a0[15:8] = wd;
                3'd2: sh_a0[7:0] = wd;
                3'd3: sh_a1[15:8] = wd;
                3'd4: sh_a1[7:0] = wd;
                default: ;
            endcase
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] wd);
        cyc(1'b1, sel, wd, 16'hFFFF, 16'h0, 1'b0, 1'b0, "cfgwr");
    endtask

    task automatic exp_is(input string tag, input logic [15:0] a, input logic [15:0] d,
                          input logic rw, input logic [1:0] want);
        // Model must agree with the hand-worked value
        check({tag, " model"}, model(a, d, rw, 1'b1), want);
        cyc(1'b0, 3'd0, 8'h0, a, d, rw, 1'b1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset match", match, 2'b00);
        check("R1 reset brk_req", {1'b0, brk_req}, 2'b00);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R1 post-reset brk_req", {1'b0, brk_req}, 2'b00);
        // R1: registers cleared -> address 0 matches once enabled in dual mode
        wr(3'd0, 8'h03);
        exp_is("R1 zeroed sets", 16'h0000, 16'h5555, 1'b1, 2'b11);

        wr(3'd1, 8'h12); wr(3'd2, 8'h34); wr(3'd3, 8'hAB); wr(3'd4, 8'hCD);
        wr(3'd0, 8'h01);
        exp_is("R5 full hit", 16'h1234, 16'hABCD, 1'b1, 2'b01);
        exp_is("R5 data miss", 16'h1234, 16'hABCC, 1'b1, 2'b00);
        exp_is("R4 lo miss", 16'h1235, 16'hABCD, 1'b1, 2'b00);
        exp_is("R4 hi miss", 16'h1334, 16'hABCD, 1'b1, 2'b00);
        exp_is("R5 ch1 addr in full", 16'hABCD, 16'hABCD, 1'b1, 2'b00);
        cyc(1'b0, 3'd0, 8'h0, 16'h1234, 16'hABCD, 1'b1, 1'b0, "R3 invalid");
        exp_is("R7 write any", 16'h1234, 16'hABCD, 1'b0, 2'b01);

        wr(3'd0, 8'h11);
        exp_is("R9 ch1 dir in full", 16'h1234, 16'hABCD, 1'b1, 2'b01);
        wr(3'd0, 8'h0D);
        exp_is("R8 read hit", 16'h1234, 16'hABCD, 1'b1, 2'b01);
        exp_is("R8 read-only miss", 16'h1234, 16'hABCD, 1'b0, 2'b00);
        wr(3'd0, 8'h05);
        exp_is("R8 write hit", 16'h1234, 16'hABCD, 1'b0, 2'b01);
        exp_is("R8 write-only miss", 16'h1234, 16'hABCD, 1'b1, 2'b00);
        wr(3'd0, 8'h4D);
        exp_is("R10 prog ignores dir", 16'h1234, 16'hABCD, 1'b0, 2'b01);

        wr(3'd0, 8'h03);
        exp_is("R6 dual ch1", 16'hABCD, 16'h0000, 1'b0, 2'b10);
        exp_is("R6 dual ch0 no data", 16'h1234, 16'h9999, 1'b1, 2'b01);
        wr(3'd0, 8'h33);
        exp_is("R8 dual ch1 read-only", 16'hABCD, 16'h0, 1'b0, 2'b00);
        wr(3'd0, 8'hB3);
        exp_is("R10 dual ch1 prog", 16'hABCD, 16'h0, 1'b0, 2'b10);

        wr(3'd0, 8'h02);
        exp_is("R2 disabled", 16'h1234, 16'hABCD, 1'b1, 2'b00);
        // R12: enable written in the same cycle as a hitting bus cycle
        wr(3'd0, 8'h00);
        cyc(1'b1, 3'd0, 8'h01, 16'h1234, 16'hABCD, 1'b1, 1'b1, "R12 same cycle");
        exp_is("R12 next cycle", 16'h1234, 16'hABCD, 1'b1, 2'b01);

        for (int i = 0; i < 600; i++) begin
            logic [15:0] a, d;
            logic [2:0] s;
            int pick = $urandom_range(0, 9);
            if (pick == 0) begin
                s = 3'($urandom_range(0, 5));
                cyc(1'b1, s, 8'($urandom), 16'($urandom), 16'($urandom),
                    1'($urandom), 1'($urandom), "R12 rand wr");
            end else begin
                a = (pick < 4) ? sh_a0 : (pick < 7) ? sh_a1 : 16'($urandom);
                d = (pick[0]) ? sh_a1 : 16'($urandom);
                cyc(1'b0, 3'd0, 8'h0, a, d, 1'($urandom),
                    ($urandom_range(0, 7) != 0), "R4 rand cmp");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule